// File: doc/BRIEF.md
# Reset Sequencer with Source Detection

This block generates the chip-level reset sequence. Five sources can request a reset: an external low level on the bidirectional reset pin, power-on, low supply voltage, watchdog expiry and a clock-monitor fault. The core is held in reset from the moment a request is seen. The block then pulls the open-drain reset pin low for a fixed number of clock cycles, releases it and waits a fixed settling time. At the end of that wait it reads the pin back.

If the pin still reads low, something outside the chip is holding it, and the reset is treated as an external, power-on or low-voltage event. If the pin reads high, the block picks the vector from the internal pending flags. A clock-monitor fault wins over a watchdog expiry. The chosen vector is presented as a one-hot select, and the core reset is released in the same cycle that the select is strobed valid.

Reset entry is combinational from the request inputs and does not wait for a clock edge. Leaving reset is fully synchronous and needs the clock running. The pin drive time is 128 cycles plus a modelled synchronisation latency of 4 cycles, and the settling wait is 64 cycles. All three values are parameters.

Top module: `rst_seq_top`

## Requirements
- R1: After the synchronous reset `rst_n` is released with no request present, `pin_oe`, `core_rst` and `vec_valid` are 0, and `vec_sel` is 3'b000.
- R2: In any cycle where `req_por`, `req_lvd` or `req_wdog` is high, `core_rst` is 1 in that same cycle.
- R3: `req_ckfail` has no effect unless `ckmon_en` is 1 and `selfclk_en` is 0. When it has no effect, `pin_oe` and `core_rst` stay 0.
- R4: After a request is sampled at a clock edge, `pin_oe` is 1 for exactly 132 consecutive cycles, starting in the following cycle.
- R5: `pin_in` is sampled in the 64th cycle after `pin_oe` falls. `vec_valid` is 1 for exactly one cycle, the 65th, and in that cycle `core_rst` is 0 when no request is present.
- R6: If `pin_in` is low at the sample point, `vec_sel` is 3'b001 (bit 0 = external/power-on/low-voltage), even when a watchdog reset is pending.
- R7: If `pin_in` is high at the sample point and a clock-monitor reset is pending, `vec_sel` is 3'b010 (bit 1), even when a watchdog reset is also pending.
- R8: If `pin_in` is high at the sample point, only a watchdog reset is pending, `vec_sel` is 3'b100 (bit 2).
- R9: If `pin_in` is high at the sample point and nothing is pending, `vec_sel` is 3'b001.
- R10: A low level on `pin_in` while the block is idle and not driving starts a sequence: `pin_oe` is 1 in the next cycle.
- R11: A new request from power-on, low voltage, watchdog or a qualified clock fault during a sequence restarts the drive. `pin_oe` then stays 1 for 132 cycles after the restarting edge.
- R12: The watchdog and clock-monitor pending flags are cleared when the vector is latched. A following sequence without those requests selects 3'b001.
- R13: `vec_sel` is one-hot whenever `vec_valid` is 1, and `vec_sel` holds its value in every cycle where `vec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer itself |
| req_por | input | 1 | Power-on reset request, level |
| req_lvd | input | 1 | Low-voltage reset request, level |
| req_wdog | input | 1 | Watchdog timeout request, level |
| req_ckfail | input | 1 | Clock-monitor failure request, level |
| ckmon_en | input | 1 | Clock monitor enabled |
| selfclk_en | input | 1 | Self-clock mode enabled (when set, a clock failure does not reset) |
| pin_in | input | 1 | Level read back from the reset pin |
| pin_oe | output | 1 | Pull the open-drain reset pin low |
| core_rst | output | 1 | Reset to the core, active high |
| vec_sel | output | 3 | One-hot vector select: bit 0 ext/POR/LVD, bit 1 clock monitor, bit 2 watchdog |
| vec_valid | output | 1 | One-cycle strobe when `vec_sel` is latched |

## Verification
The assertions assume that the request inputs are synchronous levels, stable around each rising edge. They also assume that `pin_in` reads low whenever `pin_oe` is set, as an open-drain pin does. The bench enforces this by building `pin_in` as the wired-AND of the block's own drive and an external pull-down that it controls. It changes all inputs just after a rising edge. It asserts the external pull-down only while idle or during the settling wait, never mid-edge. This gives the sample point a defined level.

// File: rtl/rst_seq_pkg.sv
// Package: shared phase encoding and vector-select bit positions for the
// reset sequencer. Assumes a three-entry one-hot vector select.
package rst_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    localparam int VEC_W  = 3;
    localparam int V_EXT  = 0;   // external / power-on / low-voltage
    localparam int V_CKM  = 1;   // clock monitor
    localparam int V_WDG  = 2;   // watchdog
endpackage

// File: rtl/rst_seq_req.sv
// Request qualifier: merges the internal reset requests and keeps the
// watchdog and clock-monitor pending flags. Assumes requests are
// synchronous levels; pending flags clear only at the sample point.
module rst_seq_req (
    input  logic clk,
    input  logic rst_n,
    input  logic req_por,
    input  logic req_lvd,
    input  logic req_wdog,
    input  logic req_ckfail,
    input  logic ckmon_en,
    input  logic selfclk_en,
    input  logic sample,
    output logic int_req,
    output logic pend_ck,
    output logic pend_wd
);
    logic ck_qual;

    // Clock fault resets only with the monitor on and self-clock mode off.
    always_comb begin
        ck_qual = req_ckfail & ckmon_en & ~selfclk_en;
        int_req = req_por | req_lvd | req_wdog | ck_qual;
    end

    // Pending clock-monitor flag: set on request, cleared when latched.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_ck <= 1'b0;
        else if (ck_qual) pend_ck <= 1'b1;
        else if (sample)  pend_ck <= 1'b0;
    end

    // Pending watchdog flag: set on request, cleared when latched.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_wd <= 1'b0;
        else if (req_wdog) pend_wd <= 1'b1;
        else if (sample)   pend_wd <= 1'b0;
    end
endmodule

// File: rtl/rst_seq_timer.sv
// Phase timer: idle -> drive pin low for LOW_CYC cycles -> settle for
// WAIT_CYC cycles -> sample. Any start restarts the low phase from zero.
// Assumes pin_in reads low while pin_oe is set.
module rst_seq_timer #(
    parameter int LOW_CYC  = 132,
    parameter int WAIT_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic int_req,
    input  logic pin_in,
    output logic pin_oe,
    output logic busy,
    output logic start,
    output logic sample
);
    import rst_seq_pkg::*;

    localparam int MAXC = (LOW_CYC > WAIT_CYC) ? LOW_CYC : WAIT_CYC;
    localparam int CW   = $clog2(MAXC) + 1;

    phase_e        phase;
    logic [CW-1:0] cnt;
    logic          last_low;
    logic          last_wait;

    // Start decode and end-of-phase detection.
    always_comb begin
        start     = int_req | ((phase == PH_IDLE) & ~pin_in);
        last_low  = (cnt == CW'(LOW_CYC - 1));
        last_wait = (cnt == CW'(WAIT_CYC - 1));
        sample    = (phase == PH_WAIT) & last_wait & ~start;
        pin_oe    = (phase == PH_LOW);
        busy      = (phase != PH_IDLE);
    end

    // Phase and cycle counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (start) begin
            phase <= PH_LOW;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_LOW: begin
                    if (last_low) begin
                        phase <= PH_WAIT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_WAIT: begin
                    if (last_wait) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end
endmodule

// File: rtl/rst_seq_vec.sv
// Vector selector: at the sample point picks the one-hot vector from the
// pin level and pending flags (pin low, then clock monitor, then watchdog,
// else external) and strobes valid for one cycle.
module rst_seq_vec (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sample,
    input  logic                         pin_in,
    input  logic                         pend_ck,
    input  logic                         pend_wd,
    output logic [rst_seq_pkg::VEC_W-1:0] vec_sel,
    output logic                         vec_valid
);
    import rst_seq_pkg::*;

    logic [VEC_W-1:0] pick;

    // Priority decode into a one-hot select.
    always_comb begin
        pick = '0;
        if (!pin_in)      pick[V_EXT] = 1'b1;
        else if (pend_ck) pick[V_CKM] = 1'b1;
        else if (pend_wd) pick[V_WDG] = 1'b1;
        else              pick[V_EXT] = 1'b1;
    end

    // Latch the select and raise the one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_sel   <= '0;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= sample;
            if (sample) vec_sel <= pick;
        end
    end
endmodule

// File: rtl/rst_seq_top.sv
// Reset sequencer top: qualifies requests, times the pin drive and the
// settling wait, and latches the reset vector. Core reset entry is
// combinational from the requests; exit is synchronous to clk.
module rst_seq_top #(
    parameter int LOW_BASE = 128,
    parameter int SYNC_LAT = 4,
    parameter int WAIT_CYC = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_por,
    input  logic       req_lvd,
    input  logic       req_wdog,
    input  logic       req_ckfail,
    input  logic       ckmon_en,
    input  logic       selfclk_en,
    input  logic       pin_in,
    output logic       pin_oe,
    output logic       core_rst,
    output logic [2:0] vec_sel,
    output logic       vec_valid
);
    localparam int LOW_CYC = LOW_BASE + SYNC_LAT;

    logic int_req, pend_ck, pend_wd, busy, start, sample;

    rst_seq_req u_req (
        .clk(clk), .rst_n(rst_n),
        .req_por(req_por), .req_lvd(req_lvd), .req_wdog(req_wdog),
        .req_ckfail(req_ckfail), .ckmon_en(ckmon_en), .selfclk_en(selfclk_en),
        .sample(sample), .int_req(int_req), .pend_ck(pend_ck), .pend_wd(pend_wd)
    );

    rst_seq_timer #(.LOW_CYC(LOW_CYC), .WAIT_CYC(WAIT_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .int_req(int_req), .pin_in(pin_in),
        .pin_oe(pin_oe), .busy(busy), .start(start), .sample(sample)
    );

    rst_seq_vec u_vec (
        .clk(clk), .rst_n(rst_n), .sample(sample), .pin_in(pin_in),
        .pend_ck(pend_ck), .pend_wd(pend_wd),
        .vec_sel(vec_sel), .vec_valid(vec_valid)
    );

    // Core reset: held through the sequence, entered at once on a request.
    always_comb core_rst = busy | start;
endmodule

// File: rtl/rst_seq_chk.sv
// Checker for rst_seq_top: port-level temporal properties. Assumes
// synchronous request levels and a pin that reads low while driven.
module rst_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_por,
    input logic       req_lvd,
    input logic       req_wdog,
    input logic       pin_oe,
    input logic       core_rst,
    input logic [2:0] vec_sel,
    input logic       vec_valid
);
    // R2: a power-on, low-voltage or watchdog request asserts core reset at once.
    p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_por || req_lvd || req_wdog) |-> core_rst);

    // R4: the pin is never driven without the core held in reset.
    p_oe_in_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> core_rst);

    // R11: a power-on request leads to pin drive in the next cycle.
    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_por |=> pin_oe);

    // R5: the strobe never coincides with pin drive.
    p_valid_nodrive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> !pin_oe);

    // R13: the strobe lasts one cycle.
    p_valid_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    // R13: the select is one-hot when strobed.
    p_vec_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ($countones(vec_sel) == 1));

    // R13: the select holds between strobes.
    p_vec_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> $stable(vec_sel));
endmodule

bind rst_seq_top rst_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_por(req_por), .req_lvd(req_lvd),
    .req_wdog(req_wdog), .pin_oe(pin_oe), .core_rst(core_rst),
    .vec_sel(vec_sel), .vec_valid(vec_valid)
);

// File: tb/rst_seq_top_bench.sv
module rst_seq_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_por = 0, req_lvd = 0, req_wdog = 0, req_ckfail = 0;
    logic       ckmon_en = 0, selfclk_en = 0;
    logic       ext_low = 0;
    logic       pin_in, pin_oe, core_rst, vec_valid;
    logic [2:0] vec_sel;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // reference model state
    int       m_ph = 0;
    int       m_left = 0;
    bit       m_pc = 0, m_pw = 0, m_valid = 0;
    bit [2:0] m_vec = 0;

    always #5 clk = ~clk;

    assign pin_in = ~(pin_oe | ext_low);

    rst_seq_top u_rst_seq_top (
        .clk(clk), .rst_n(rst_n), .req_por(req_por), .req_lvd(req_lvd),
        .req_wdog(req_wdog), .req_ckfail(req_ckfail), .ckmon_en(ckmon_en),
        .selfclk_en(selfclk_en), .pin_in(pin_in), .pin_oe(pin_oe),
        .core_rst(core_rst), .vec_sel(vec_sel), .vec_valid(vec_valid)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
        end
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        bit ckq, anyi;
        ckq  = req_ckfail && ckmon_en && !selfclk_en;
        anyi = req_por || req_lvd || req_wdog || ckq;
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_pc = 0; m_pw = 0; m_valid = 0; m_vec = 0;
        end else begin
            m_valid = 0;
            if (req_wdog) m_pw = 1;
            if (ckq) m_pc = 1;
            if (anyi || (m_ph == 0 && ext_low)) begin
                m_ph = 1; m_left = 132;
            end else if (m_ph == 1) begin
                m_left--;
                if (m_left == 0) begin m_ph = 2; m_left = 64; end
            end else if (m_ph == 2) begin
                m_left--;
                if (m_left == 0) begin
                    m_vec = ext_low ? 3'b001 : m_pc ? 3'b010 : m_pw ? 3'b100 : 3'b001;
                    m_pc = 0; m_pw = 0; m_valid = 1; m_ph = 0;
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        bit ckq, exp_core;
        if (rst_n) begin
            ckq = req_ckfail && ckmon_en && !selfclk_en;
            exp_core = (m_ph != 0) || req_por || req_lvd || req_wdog || ckq || (m_ph == 0 && ext_low);
            chk(pin_oe == (m_ph == 1), "R4 pin_oe", pin_oe, m_ph == 1);
            chk(core_rst == exp_core, "R2 core_rst", core_rst, exp_core);
            chk(vec_valid == m_valid, "R5 vec_valid", vec_valid, m_valid);
            chk(vec_sel == m_vec, "R13 vec_sel", vec_sel, m_vec);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic pulse(input int which);
        @(posedge clk); #1;
        case (which)
            0: req_por = 1;
            1: req_lvd = 1;
            2: req_wdog = 1;
            default: req_ckfail = 1;
        endcase
        @(negedge clk);
        if (which < 3) chk(core_rst == 1, "R2 entry", core_rst, 1);
        @(posedge clk); #1;
        req_por = 0; req_lvd = 0; req_wdog = 0; req_ckfail = 0;
    endtask

    task automatic run(input bit hold_low, output int oe_n, output int gap_n);
        oe_n = 0; gap_n = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (pin_oe) oe_n++;
            else if (oe_n > 0) gap_n++;
            if (vec_valid) break;
            if (hold_low && !pin_oe && oe_n > 0) begin #1; ext_low = 1; end
        end
        if (hold_low) begin #1; ext_low = 0; end
    endtask

    initial begin
        int oe_n, gap_n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(pin_oe == 0, "R1 pin_oe", pin_oe, 0);
        chk(core_rst == 0, "R1 core_rst", core_rst, 0);
        chk(vec_valid == 0, "R1 vec_valid", vec_valid, 0);
        chk(vec_sel == 0, "R1 vec_sel", vec_sel, 0);

        // R3: clock fault ignored while monitor off or self-clock on
        @(posedge clk); #1; req_ckfail = 1;
        repeat (4) @(posedge clk);
        #1 selfclk_en = 1; ckmon_en = 1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(pin_oe == 0, "R3 pin_oe", pin_oe, 0);
        chk(core_rst == 0, "R3 core_rst", core_rst, 0);
        #1 req_ckfail = 0; selfclk_en = 0;

        // R7 with R4/R5 timing: qualified clock fault
        pulse(3);
        run(0, oe_n, gap_n);
        chk(oe_n == 132, "R4 drive length", oe_n, 132);
        chk(gap_n == 65, "R5 release to valid", gap_n, 65);
        chk(core_rst == 0, "R5 core released", core_rst, 0);
        chk(vec_sel == 3'b010, "R7 clock monitor", vec_sel, 3'b010);

        // R8: watchdog only
        pulse(2);
        run(0, oe_n, gap_n);
        chk(vec_sel == 3'b100, "R8 watchdog", vec_sel, 3'b100);

        // R7: clock fault beats watchdog
        @(posedge clk); #1; req_wdog = 1; req_ckfail = 1;
        @(posedge clk); #1; req_wdog = 0; req_ckfail = 0;
        run(0, oe_n, gap_n);
        chk(vec_sel == 3'b010, "R7 priority", vec_sel, 3'b010);

        // R9: power-on, nothing pending
        pulse(0);
        run(0, oe_n, gap_n);
        chk(vec_sel == 3'b001, "R9 none pending", vec_sel, 3'b001);
        repeat (5) @(negedge clk);
        chk(vec_sel == 3'b001 && vec_valid == 0, "R13 hold", vec_sel, 3'b001);

        // R6: watchdog pending but pin held low at sample
        pulse(2);
        run(1, oe_n, gap_n);
        chk(vec_sel == 3'b001, "R6 pin low", vec_sel, 3'b001);

        // R12: pending watchdog cleared; low voltage now selects external
        pulse(1);
        run(0, oe_n, gap_n);
        chk(vec_sel == 3'b001, "R12 pending cleared", vec_sel, 3'b001);

        // R10: external pin low while idle
        @(posedge clk); #1; ext_low = 1;
        @(negedge clk);
        chk(pin_oe == 0, "R10 before edge", pin_oe, 0);
        @(posedge clk); #1; ext_low = 0;
        @(negedge clk);
        chk(pin_oe == 1, "R10 drive starts", pin_oe, 1);
        run(0, oe_n, gap_n);
        chk(vec_sel == 3'b001, "R10 vector", vec_sel, 3'b001);

        // R11: restart mid-drive
        pulse(2);
        repeat (49) @(posedge clk);
        pulse(0);
        run(0, oe_n, gap_n);
        chk(oe_n == 132, "R11 restarted drive", oe_n, 132);
        chk(vec_sel == 3'b100, "R11 vector", vec_sel, 3'b100);

        repeat (3) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule